// File: doc/BRIEF.md
# Timestamp Code Insertion Sequencer

This block sits on the transmit side of a cell-based circuit transport and supplies the single header bit that carries a 4-bit residual timestamp code. It is active only while signaling mode is off. Each outgoing cell is announced by a one-cycle start strobe together with its 3-bit sequence number. When the cell with sequence number 0 starts, the block asks an external timestamp source for a fresh code through a request/acknowledge handshake and parks the answer in a pending register.

When the cell with sequence number 1 starts, the pending code moves into the held register. Its four bits then go out one per odd-numbered cell, most significant first. Even-numbered cells carry a zero. If no code has arrived by the time sequence number 1 starts, the held code is sent again and a sticky late flag is raised. A held code is never replaced before all four of its bits have been sent, even if the sequence numbering restarts early.

The insertion bit is registered. It changes one clock after a start strobe and stays stable until the next strobe.

Top module: `tsc_insert_seq`

## Requirements
- R1: After reset, `ts_req_o`, `ins_bit_o` and `late_o` are 0, and the held code is 0000.
- R2: With signaling off, a start strobe with sequence number 0 raises `ts_req_o` on the next cycle, provided no request is outstanding and no fetched code is waiting. The request stays high until `ts_ack_i` is seen. On that acknowledge, `ts_code_i` is captured and the request is low on the next cycle.
- R3: At a sequence-1 strobe where all bits of the previous code have been sent, a waiting code becomes the held code. The strobes with sequence numbers 1, 3, 5 and 7 then drive `ins_bit_o` to held bits 3, 2, 1 and 0 in that order. The value appears one cycle after the strobe and holds until the next strobe.
- R4: A strobe with an even sequence number (0, 2, 4 or 6) drives `ins_bit_o` to 0.
- R5: At a sequence-1 strobe with no fetched code waiting, the held code stays in place and is sent again. `late_o` is set and stays 1 until reset.
- R6: The held code cannot be replaced until four odd-numbered cells have been sent since it was loaded. A sequence-1 strobe that arrives earlier continues the old code, and a waiting new code is kept for a later sequence-1 strobe.
- R7: While `sig_mode_i` is 1: no request is raised, any outstanding request is dropped, acknowledges are ignored, strobes drive `ins_bit_o` to 0, and strobes do not advance the held code or its bit count.
- R8: An acknowledge while no request is outstanding does not change the waiting code or its valid state.
- R9: An acknowledge in the same cycle as a sequence-1 strobe arrives too late for that cell. The cell counts as late under R5, and the captured code is used at the next sequence-1 strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_mode_i | input | 1 | Signaling mode active; the sequencer is idle while high |
| cell_start_i | input | 1 | One-cycle strobe: a cell starts |
| cell_sn_i | input | 3 | Sequence number of the starting cell |
| ts_req_o | output | 1 | Request for a new timestamp code |
| ts_ack_i | input | 1 | Timestamp source has placed a code on `ts_code_i` |
| ts_code_i | input | 4 | Timestamp code from the external source |
| ins_bit_o | output | 1 | Header insertion bit for the current cell |
| late_o | output | 1 | Sticky flag: a code arrived too late at least once |

## Verification
The hardest situation to reach is a sequence-1 strobe that arrives while the held code still has bits left to send. Only that situation shows whether a waiting code overwrites a partly sent one. The stimulus gets there by loading a code, sending only two odd cells, and then restarting at sequence 0 and fetching a new code. It then issues sequence 1 again and checks that the old code's remaining bits come out first. A second hard case is an acknowledge landing in the same cycle as the sequence-1 strobe. The bench drives both inputs on one edge and checks that the old code is reused and the new code comes out one frame later.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int DEF_SN_W = 3;

    typedef enum logic [1:0] {
        CELL_NONE  = 2'd0,
        CELL_FETCH = 2'd1,
        CELL_LOAD  = 2'd2,
        CELL_ODD   = 2'd3
    } cell_kind_e;

    // Classify a strobe: sequence 0 starts a fetch, sequence 1 is the load point,
    // other odd numbers carry code bits, everything else carries nothing.
    function automatic cell_kind_e classify(input logic start, input logic sig,
                                            input logic is_zero, input logic is_one,
                                            input logic is_odd);
        cell_kind_e k;
        k = CELL_NONE;
        if (start && !sig) begin
            if (is_zero)     k = CELL_FETCH;
            else if (is_one) k = CELL_LOAD;
            else if (is_odd) k = CELL_ODD;
        end
        return k;
    endfunction

endpackage

// File: rtl/tsc_fetch.sv
module tsc_fetch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_mode_i,
    input  logic              fetch_go_i,
    input  logic              consume_i,
    input  logic              ack_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              req_o,
    output logic              pend_valid_o,
    output logic [CODE_W-1:0] pend_code_o
);

    typedef struct packed {
        logic              req;
        logic              pvalid;
        logic [CODE_W-1:0] pcode;
    } fetch_st_t;

    fetch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (consume_i) begin
            st_d.pvalid = 1'b0;
        end
        if (sig_mode_i) begin
            st_d.req = 1'b0;
        end else begin
            if (fetch_go_i && !st_q.req && !st_q.pvalid) begin
                st_d.req = 1'b1;
            end
            if (ack_i && st_q.req) begin
                st_d.req    = 1'b0;
                st_d.pvalid = 1'b1;
                st_d.pcode  = code_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o        = st_q.req;
    assign pend_valid_o = st_q.pvalid;
    assign pend_code_o  = st_q.pcode;

    p_req_drops_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && ack_i) |=> !req_o);

    p_no_req_in_sig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_mode_i |=> !req_o);

    p_stray_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.req && !consume_i) |=> ($stable(pend_code_o) && $stable(pend_valid_o)));

endmodule

// File: rtl/tsc_hold.sv
module tsc_hold #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cell_i,
    input  logic              odd_cell_i,
    input  logic              pend_valid_i,
    input  logic [CODE_W-1:0] pend_code_i,
    output logic              consume_o,
    output logic [CODE_W-1:0] held_nxt_o,
    output logic              late_o
);

    localparam int LEFT_W = (CODE_W > 2) ? $clog2(CODE_W) : 1;

    typedef struct packed {
        logic [CODE_W-1:0] held;
        logic [LEFT_W-1:0] left;
        logic              late;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     load_ok;

    always_comb begin
        st_d      = st_q;
        consume_o = 1'b0;
        load_ok   = load_cell_i && (st_q.left == '0);
        if (load_ok) begin
            if (pend_valid_i) begin
                st_d.held = pend_code_i;
                consume_o = 1'b1;
            end else begin
                st_d.late = 1'b1;
            end
            st_d.left = LEFT_W'(CODE_W - 1);
        end else if ((load_cell_i || odd_cell_i) && (st_q.left != '0)) begin
            st_d.left = st_q.left - LEFT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_nxt_o = st_d.held;
    assign late_o     = st_q.late;

    p_late_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        late_o |=> late_o);

    p_held_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left != '0) |=> $stable(st_q.held));

endmodule

// File: rtl/tsc_bitsel.sv
module tsc_bitsel #(
    parameter int SN_W   = 3,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_start_i,
    input  logic              sig_mode_i,
    input  logic [SN_W-1:0]   sn_i,
    input  logic [CODE_W-1:0] held_nxt_i,
    output logic              ins_bit_o
);

    logic              bit_d, bit_q;
    logic [CODE_W-1:0] msb_first;
    logic [SN_W-2:0]   slot;

    always_comb begin
        for (int i = 0; i < CODE_W; i++) begin
            msb_first[i] = held_nxt_i[CODE_W-1-i];
        end
        slot  = sn_i[SN_W-1:1];
        bit_d = bit_q;
        if (cell_start_i) begin
            bit_d = (!sig_mode_i && sn_i[0]) ? msb_first[slot] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign ins_bit_o = bit_q;

    p_even_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start_i && !sn_i[0]) |=> !ins_bit_o);

    p_sig_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start_i && sig_mode_i) |=> !ins_bit_o);

    p_bit_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_start_i |=> $stable(ins_bit_o));

endmodule

// File: rtl/tsc_insert_seq.sv
module tsc_insert_seq
    import tsc_pkg::*;
#(
    parameter int SN_W = DEF_SN_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sig_mode_i,
    input  logic                       cell_start_i,
    input  logic [SN_W-1:0]            cell_sn_i,
    output logic                       ts_req_o,
    input  logic                       ts_ack_i,
    input  logic [(2**(SN_W-1))-1:0]   ts_code_i,
    output logic                       ins_bit_o,
    output logic                       late_o
);

    localparam int CODE_W = 2 ** (SN_W - 1);

    cell_kind_e        kind;
    logic              fetch_go, load_cell, odd_cell;
    logic              consume, pend_valid;
    logic [CODE_W-1:0] pend_code, held_nxt;

    always_comb begin
        kind      = classify(cell_start_i, sig_mode_i, cell_sn_i == '0,
                             cell_sn_i == SN_W'(1), cell_sn_i[0]);
        fetch_go  = (kind == CELL_FETCH);
        load_cell = (kind == CELL_LOAD);
        odd_cell  = (kind == CELL_ODD);
    end

    tsc_fetch #(.CODE_W(CODE_W)) i_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_mode_i   (sig_mode_i),
        .fetch_go_i   (fetch_go),
        .consume_i    (consume),
        .ack_i        (ts_ack_i),
        .code_i       (ts_code_i),
        .req_o        (ts_req_o),
        .pend_valid_o (pend_valid),
        .pend_code_o  (pend_code)
    );

    tsc_hold #(.CODE_W(CODE_W)) i_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_cell_i  (load_cell),
        .odd_cell_i   (odd_cell),
        .pend_valid_i (pend_valid),
        .pend_code_i  (pend_code),
        .consume_o    (consume),
        .held_nxt_o   (held_nxt),
        .late_o       (late_o)
    );

    tsc_bitsel #(.SN_W(SN_W), .CODE_W(CODE_W)) i_bitsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .cell_start_i (cell_start_i),
        .sig_mode_i   (sig_mode_i),
        .sn_i         (cell_sn_i),
        .held_nxt_i   (held_nxt),
        .ins_bit_o    (ins_bit_o)
    );

    p_req_needs_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts_req_o) |-> $past(cell_start_i && cell_sn_i == '0 && !sig_mode_i));

endmodule

// File: tb/test_tsc_insert_seq.sv
module test_tsc_insert_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_mode = 1'b0;
    logic       cell_start = 1'b0;
    logic [2:0] cell_sn = '0;
    logic       ts_ack = 1'b0;
    logic [3:0] ts_code = '0;
    logic       ts_req, ins_bit, late;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tsc_insert_seq i_tsc_insert_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_mode_i   (sig_mode),
        .cell_start_i (cell_start),
        .cell_sn_i    (cell_sn),
        .ts_req_o     (ts_req),
        .ts_ack_i     (ts_ack),
        .ts_code_i    (ts_code),
        .ins_bit_o    (ins_bit),
        .late_o       (late)
    );

    typedef struct packed {
        logic [3:0] code;
        logic [7:0] exp;   // expected insertion bit, indexed by sequence number
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'hA, 8'h22}, '{4'h5, 8'h88}, '{4'h9, 8'h82},
        '{4'h6, 8'h28}, '{4'h0, 8'h00}, '{4'hF, 8'hAA}
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] sn);
        @(negedge clk);
        cell_start = 1'b1;
        cell_sn    = sn;
        @(negedge clk);
        cell_start = 1'b0;
    endtask

    task automatic give_ack(input logic [3:0] c);
        @(negedge clk);
        ts_ack  = 1'b1;
        ts_code = c;
        @(negedge clk);
        ts_ack  = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ts_req, 1'b0, "R1 req after reset");
        chk(ins_bit, 1'b0, "R1 bit after reset");
        chk(late, 1'b0, "R1 late after reset");

        // R9: ack lands together with the sequence-1 strobe
        strobe(3'd0);
        chk(ts_req, 1'b1, "R2 request raised");
        @(negedge clk);
        cell_start = 1'b1; cell_sn = 3'd1; ts_ack = 1'b1; ts_code = 4'hF;
        @(negedge clk);
        cell_start = 1'b0; ts_ack = 1'b0;
        chk(ins_bit, 1'b0, "R9 same-cycle ack uses old code (R1 zero code)");
        chk(late, 1'b1, "R9 late set");
        chk(ts_req, 1'b0, "R2 request dropped on ack");
        for (int s = 2; s < 8; s++) begin
            strobe(3'(s));
            chk(ins_bit, 1'b0, "R9 old code bits");
        end
        strobe(3'd0);
        chk(ts_req, 1'b0, "R2 no request while code waits");
        for (int s = 1; s < 8; s++) begin
            strobe(3'(s));
            chk(ins_bit, s[0], "R9 captured code used next frame");
        end

        // R5: no ack before sequence 1, previous code F reused
        strobe(3'd0);
        chk(ts_req, 1'b1, "R2 request for late frame");
        for (int s = 1; s < 8; s++) begin
            strobe(3'(s));
            chk(ins_bit, s[0], "R5 previous code reused");
        end
        chk(late, 1'b1, "R5 late sticky");
        chk(ts_req, 1'b1, "R2 request held until ack");
        give_ack(4'h0);
        strobe(3'd0);
        for (int s = 1; s < 8; s++) begin
            strobe(3'(s));
            chk(ins_bit, 1'b0, "R3 delayed code 0000");
        end

        // R3/R4 table walk
        foreach (VECS[v]) begin
            strobe(3'd0);
            chk(ins_bit, VECS[v].exp[0], "R4 sequence 0 bit");
            chk(ts_req, 1'b1, "R2 table request");
            repeat (2) @(negedge clk);
            chk(ts_req, 1'b1, "R2 request waits");
            give_ack(VECS[v].code);
            chk(ts_req, 1'b0, "R2 request cleared");
            for (int s = 1; s < 8; s++) begin
                strobe(3'(s));
                chk(ins_bit, VECS[v].exp[s], s[0] ? "R3 code bit" : "R4 even bit");
                if (s == 1) begin
                    @(negedge clk);
                    chk(ins_bit, VECS[v].exp[1], "R3 bit held between strobes");
                end
            end
        end

        // R8: stray ack with no request, held code is F
        give_ack(4'h0);
        // R7: signaling mode
        sig_mode = 1'b1;
        strobe(3'd0);
        chk(ts_req, 1'b0, "R7 no request in signaling");
        strobe(3'd1);
        chk(ins_bit, 1'b0, "R7 bit zero in signaling");
        give_ack(4'h0);
        strobe(3'd3);
        chk(ins_bit, 1'b0, "R7 odd bit zero in signaling");
        sig_mode = 1'b0;
        for (int s = 1; s < 8; s++) begin
            strobe(3'(s));
            chk(ins_bit, s[0], "R8 stray ack ignored, F kept (R7 no advance)");
        end

        // R6: early restart must not replace a partly sent code
        strobe(3'd0);
        give_ack(4'hC);
        strobe(3'd1);
        chk(ins_bit, 1'b1, "R6 X bit3");
        strobe(3'd3);
        chk(ins_bit, 1'b1, "R6 X bit2");
        strobe(3'd0);
        chk(ts_req, 1'b1, "R6 fetch during partial");
        give_ack(4'h3);
        strobe(3'd1);
        chk(ins_bit, 1'b1, "R6 old code continues");
        strobe(3'd3);
        chk(ins_bit, 1'b1, "R6 old code continues 2");
        strobe(3'd5);
        chk(ins_bit, 1'b0, "R6 old bit1");
        strobe(3'd7);
        chk(ins_bit, 1'b0, "R6 old bit0");
        strobe(3'd0);
        chk(ts_req, 1'b0, "R6 code still waiting");
        strobe(3'd1);
        chk(ins_bit, 1'b0, "R6 new bit3");
        strobe(3'd3);
        chk(ins_bit, 1'b0, "R6 new bit2");
        strobe(3'd5);
        chk(ins_bit, 1'b1, "R6 new bit1");
        strobe(3'd7);
        chk(ins_bit, 1'b1, "R6 new bit0");

        // R1: reset clears late flag and held code
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(late, 1'b0, "R1 late cleared");
        strobe(3'd1);
        chk(ins_bit, 1'b0, "R1 held code cleared");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule